// File: doc/BRIEF.md
# Platform Reset Sequencer

This block drives the active-low reset that holds the whole platform (processor, memory controller, boot storage, add-in cards) in reset until power is trustworthy. It combines three sources of reset: loss of the main supply's power-good, a hard-reset request written by software to a reset control register, and a debounced system-reset push button. Release needs both the main and the core-regulator power-good inputs to be high. The reset then stays asserted for a minimum hold time, and that hold starts again whenever a new request arrives.

Both power-good inputs are asynchronous and pass through two-flop synchronizers. A low pulse on main power-good becomes a power-loss event only once it has lasted a set number of ticks of the slow real-time-clock enable; a shorter dip is treated as a glitch. An accepted button press waits for the SMBus to report idle, so that a transaction in flight is not cut off. If the bus never goes idle, a timeout forces the reset. A three-bit cause register shows why the last reset happened, and it stays readable after release.

Every duration is a parameter in core clock cycles: the hold (1 ms in the target system), the debounce (16 ms) and the SMBus wait limit (25 ms). The register write is a one-cycle strobe with no back-pressure, and every strobe is taken in the cycle it is presented.

Top module: `plat_rst_seq`

## Requirements
- R1: While `rst_n` is low, `plat_rst_n` is 0 and `rst_cause` is 3'b001. In `rst_cause`, bit 0 is power loss, bit 1 is software and bit 2 is the button.
- R2: Each power-good input is synchronized by two flops. Reset is released on the HOLD_CYC-th consecutive clock edge at which both synchronized power-goods are high and no request is present, which is HOLD_CYC+2 edges after the later input rises. It is never released while either power-good is low.
- R3: While reset is released, a main power-good low for LOW_TICKS `rtc_tick` pulses (counted while its synchronized value is low) asserts reset on the next edge. A shorter low pulse has no effect.
- R4: While reset is asserted and main power-good is low, reset stays asserted and the hold count starts again from zero.
- R5: A `rstctl_wr` strobe whose `rstctl_wdata` has bit RST_BIT (default 2) set asserts reset on the next edge. Reset is then held for HOLD_CYC edges, so release comes HOLD_CYC+1 edges after the strobe. A strobe with that bit clear has no effect.
- R6: `sysrst_btn_n` is synchronized by two flops. A new level is accepted after DEB_CYC consecutive edges at that level. A press shorter than that is ignored.
- R7: An accepted press asserts reset on the first later edge at which `smbus_idle` is high. If the bus stays busy, reset is asserted on the TMO_CYC-th edge after acceptance.
- R8: Any request that arrives while reset is asserted restarts the hold count from zero.
- R9: On entry from the released state, `rst_cause` is replaced by the new cause bits. While reset is asserted, further causes are ORed in. While reset is released, `rst_cause` does not change.
- R10: A drop of regulator power-good while reset is released has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock of the always-on domain |
| rst_n | input | 1 | Asynchronous active-low reset of this block |
| main_pwr_ok_a | input | 1 | Main supply power-good, asynchronous |
| vreg_pwr_ok_a | input | 1 | Core regulator power-good, asynchronous |
| rtc_tick | input | 1 | One-cycle enable at the real-time-clock rate |
| rstctl_wr | input | 1 | Write strobe of the reset control register |
| rstctl_wdata | input | WR_W | Data written with the strobe |
| sysrst_btn_n | input | 1 | System reset button, active low, raw |
| smbus_idle | input | 1 | High when the SMBus has no transaction in flight |
| plat_rst_n | output | 1 | Platform reset, active low |
| rst_cause | output | 3 | Cause of the last reset (bit 0 power, bit 1 software, bit 2 button) |

## Verification
The bench goes after the exact release cycle after each power-good rise and after each software write. A design that counted the hold from the wrong edge, or skipped the synchronizer, would release one or two cycles early or late. It sends a main power-good dip shorter than the tick limit and a button bounce shorter than the debounce, either of which a design without filters would turn into a reset. It also writes control data with the reset bit clear, which an over-eager decode would act on. Back-to-back requests during a hold, a regulator dip in mid-hold, and a button press with the SMBus kept busy check that the hold restarts and that the timeout fires on its exact edge. They also check that the cause bits accumulate, where a design that overwrote them would show only the latest source.

// File: rtl/plat_rst_pkg.sv
package plat_rst_pkg;
  localparam int CAUSE_W   = 3;
  localparam int CAUSE_PWR = 0;
  localparam int CAUSE_SW  = 1;
  localparam int CAUSE_BTN = 2;
  typedef logic [CAUSE_W-1:0] cause_t;
  localparam cause_t CAUSE_COLD = cause_t'(1 << CAUSE_PWR);
endpackage

// File: rtl/prs_sync.sv
module prs_sync #(
  parameter int   W       = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_a,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= {W{RST_VAL}};
        else        stg[0] <= d_a;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= {W{RST_VAL}};
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/prs_pgood_filter.sv
module prs_pgood_filter #(
  parameter int LOW_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic main_ok_s,
  input  logic rtc_tick,
  output logic lost
);
  localparam int            LW      = $clog2(LOW_TICKS + 1);
  localparam logic [LW-1:0] LOW_MAX = LW'(LOW_TICKS);

  logic [LW-1:0] low_cnt;

  // Cold start counts as a confirmed loss until main power-good is seen high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              low_cnt <= LOW_MAX;
    else if (main_ok_s)                      low_cnt <= '0;
    else if (rtc_tick && low_cnt != LOW_MAX) low_cnt <= low_cnt + 1'b1;
  end

  assign lost = !main_ok_s && (low_cnt == LOW_MAX);
endmodule

// File: rtl/prs_button.sv
module prs_button #(
  parameter int DEB_CYC = 1600000,
  parameter int TMO_CYC = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_n_s,
  input  logic smbus_idle,
  output logic fire
);
  localparam int            DW       = $clog2(DEB_CYC + 1);
  localparam int            TW       = $clog2(TMO_CYC + 1);
  localparam logic [DW-1:0] DEB_LAST = DW'(DEB_CYC - 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(TMO_CYC - 1);

  logic          deb_lvl;
  logic [DW-1:0] deb_cnt;
  logic          pending;
  logic [TW-1:0] tmo_cnt;
  logic          press;

  assign press = deb_lvl && !btn_n_s && (deb_cnt == DEB_LAST);
  assign fire  = pending && (smbus_idle || tmo_cnt == TMO_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deb_lvl <= 1'b1;
      deb_cnt <= '0;
    end else if (btn_n_s == deb_lvl) begin
      deb_cnt <= '0;
    end else if (deb_cnt == DEB_LAST) begin
      deb_lvl <= btn_n_s;
      deb_cnt <= '0;
    end else begin
      deb_cnt <= deb_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      tmo_cnt <= '0;
    end else begin
      if (fire)         pending <= 1'b0;
      else if (pending) tmo_cnt <= tmo_cnt + 1'b1;
      if (press) begin
        pending <= 1'b1;
        tmo_cnt <= '0;
      end
    end
  end

  AST_FIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !press) |=> !pending); // R7
  AST_DEB_LEVEL_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(deb_lvl) |-> (deb_lvl == $past(btn_n_s))); // R6
endmodule

// File: rtl/plat_rst_seq.sv
module plat_rst_seq
  import plat_rst_pkg::*;
#(
  parameter int HOLD_CYC  = 100000,
  parameter int LOW_TICKS = 3,
  parameter int DEB_CYC   = 1600000,
  parameter int TMO_CYC   = 2500000,
  parameter int WR_W      = 8,
  parameter int RST_BIT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              main_pwr_ok_a,
  input  logic              vreg_pwr_ok_a,
  input  logic              rtc_tick,
  input  logic              rstctl_wr,
  input  logic [WR_W-1:0]   rstctl_wdata,
  input  logic              sysrst_btn_n,
  input  logic              smbus_idle,
  output logic              plat_rst_n,
  output logic [CAUSE_W-1:0] rst_cause
);
  localparam int              CW        = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0]   HOLD_LAST = CW'(HOLD_CYC - 1);
  localparam logic [WR_W-1:0] RST_MASK  = WR_W'(1) << RST_BIT;

  logic   main_s, vreg_s, btn_s;
  logic   lost, btn_fire, sw_req, any_req, pg_good;
  logic   rst_act;
  logic [CW-1:0] hold_cnt;
  cause_t cause_q, new_cause;

  prs_sync #(.W(2), .STAGES(2), .RST_VAL(1'b0)) u_pg_sync (
    .clk(clk), .rst_n(rst_n),
    .d_a({main_pwr_ok_a, vreg_pwr_ok_a}), .q({main_s, vreg_s})
  );

  prs_sync #(.W(1), .STAGES(2), .RST_VAL(1'b1)) u_btn_sync (
    .clk(clk), .rst_n(rst_n), .d_a(sysrst_btn_n), .q(btn_s)
  );

  prs_pgood_filter #(.LOW_TICKS(LOW_TICKS)) u_filter (
    .clk(clk), .rst_n(rst_n), .main_ok_s(main_s), .rtc_tick(rtc_tick), .lost(lost)
  );

  prs_button #(.DEB_CYC(DEB_CYC), .TMO_CYC(TMO_CYC)) u_button (
    .clk(clk), .rst_n(rst_n), .btn_n_s(btn_s), .smbus_idle(smbus_idle), .fire(btn_fire)
  );

  assign sw_req  = rstctl_wr && |(rstctl_wdata & RST_MASK);
  assign pg_good = main_s && vreg_s;

  always_comb begin
    new_cause            = '0;
    new_cause[CAUSE_PWR] = lost;
    new_cause[CAUSE_SW]  = sw_req;
    new_cause[CAUSE_BTN] = btn_fire;
  end
  assign any_req = |new_cause;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_act  <= 1'b1;
      hold_cnt <= '0;
      cause_q  <= CAUSE_COLD;
    end else if (any_req) begin
      rst_act  <= 1'b1;
      hold_cnt <= '0;
      cause_q  <= rst_act ? (cause_q | new_cause) : new_cause;
    end else if (rst_act) begin
      if (!pg_good)                hold_cnt <= '0;
      else if (hold_cnt == HOLD_LAST) rst_act <= 1'b0;
      else                         hold_cnt <= hold_cnt + 1'b1;
    end
  end

  assign plat_rst_n = !rst_act;
  assign rst_cause  = cause_q;

  AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_act && !pg_good) |=> !plat_rst_n); // R4
  AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(plat_rst_n) |-> ($past(hold_cnt) == HOLD_LAST)); // R2
  AST_SW_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |=> (!plat_rst_n && rst_cause[CAUSE_SW])); // R5
  AST_LOSS_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    (lost && plat_rst_n) |=> (!plat_rst_n && rst_cause[CAUSE_PWR])); // R3
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_act && any_req) |=> (hold_cnt == '0)); // R8
  AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (plat_rst_n && !any_req) |=> $stable(rst_cause)); // R9
endmodule

// File: tb/plat_rst_seq_tb.sv
module plat_rst_seq_tb;
  localparam int HOLD = 20;
  localparam int LOWT = 3;
  localparam int DEB  = 6;
  localparam int TMO  = 30;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       main_ok, vreg_ok, tick, wr, btn_n, smb;
  logic [7:0] wd;
  logic       plat_rst_n;
  logic [2:0] cause;

  always #5 clk = ~clk;

  plat_rst_seq #(.HOLD_CYC(HOLD), .LOW_TICKS(LOWT), .DEB_CYC(DEB), .TMO_CYC(TMO),
                 .WR_W(8), .RST_BIT(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .main_pwr_ok_a(main_ok), .vreg_pwr_ok_a(vreg_ok),
    .rtc_tick(tick), .rstctl_wr(wr), .rstctl_wdata(wd), .sysrst_btn_n(btn_n),
    .smbus_idle(smb), .plat_rst_n(plat_rst_n), .rst_cause(cause)
  );

  int    n_chk = 0, n_bad = 0, cyc_cnt = 0, tdiv = 0;
  string cur_req = "R1";
  bit    started = 0;

  // RTC-rate enable: one cycle in four
  always @(negedge clk) begin
    tdiv++;
    tick = (tdiv % 4 == 0);
  end

  // Behavioural reference model
  bit mq[$], vq[$], bq[$];
  int lowt, dcnt, tcnt, hcnt;
  bit dlvl, pend, act;
  bit [2:0] m_cause;

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      mq = '{1'b0, 1'b0}; vq = '{1'b0, 1'b0}; bq = '{1'b1, 1'b1};
      lowt = LOWT; dlvl = 1; dcnt = 0; pend = 0; tcnt = 0;
      act = 1; hcnt = 0; m_cause = 3'b001;
    end else begin
      bit ms, vs, bs, lost, fire, swr, press;
      bit [2:0] newc;
      ms = mq.pop_front(); mq.push_back(main_ok);
      vs = vq.pop_front(); vq.push_back(vreg_ok);
      bs = bq.pop_front(); bq.push_back(btn_n);
      lost = !ms && lowt >= LOWT;
      fire = pend && (smb || tcnt == TMO - 1);
      swr  = wr && wd[2];
      newc = {fire, swr, lost};
      press = 0;
      if (bs == dlvl) dcnt = 0;
      else if (dcnt == DEB - 1) begin press = dlvl; dlvl = bs; dcnt = 0; end
      else dcnt++;
      if (fire) pend = 0; else if (pend) tcnt++;
      if (press) begin pend = 1; tcnt = 0; end
      if (ms) lowt = 0; else if (tick && lowt < LOWT) lowt++;
      if (newc != 0) begin
        m_cause = act ? (m_cause | newc) : newc;
        act = 1; hcnt = 0;
      end else if (act) begin
        if (ms && vs) begin
          if (hcnt == HOLD - 1) act = 0; else hcnt++;
        end else hcnt = 0;
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      n_chk++;
      if (plat_rst_n !== !act || cause !== m_cause) begin
        n_bad++;
        $display("FAIL %s cycle %0d: plat_rst_n/cause actual %b/%03b expected %b/%03b",
                 cur_req, cyc_cnt, plat_rst_n, cause, !act, m_cause);
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected under 20000", cyc_cnt);
      finish_run();
    end
  end

  task automatic chk(string req, string what, int actv, int expv);
    n_chk++;
    if (actv != expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actv, expv);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic edges_until(bit lvl, int maxn, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (plat_rst_n !== lvl && n < maxn);
  endtask

  task automatic sw_write(logic [7:0] d);
    wr = 1'b1; wd = d;
    @(negedge clk);
    wr = 1'b0; wd = '0;
  endtask

  initial begin
    int n;
    rst_n = 0; main_ok = 0; vreg_ok = 0; wr = 0; wd = '0; btn_n = 1; smb = 1; tick = 0;
    cyc(5);
    cur_req = "R1";
    chk("R1", "plat_rst_n in reset", plat_rst_n, 0);
    chk("R1", "cause in reset", cause, 3'b001);
    rst_n = 1;

    // R2: only main power-good high, then regulator too
    cur_req = "R2";
    main_ok = 1;
    cyc(40);
    chk("R2", "held with regulator low", plat_rst_n, 0);
    vreg_ok = 1;
    edges_until(1, 200, n);
    chk("R2", "edges to release after both good", n, HOLD + 2);
    chk("R9", "cause after cold release", cause, 3'b001);

    // R10: regulator dip while released
    cur_req = "R10";
    vreg_ok = 0; cyc(10);
    chk("R10", "regulator dip ignored", plat_rst_n, 1);
    vreg_ok = 1; cyc(5);

    // R3: short main dip is a glitch
    cur_req = "R3";
    main_ok = 0; cyc(6); main_ok = 1; cyc(10);
    chk("R3", "short dip ignored", plat_rst_n, 1);
    chk("R9", "cause unchanged while released", cause, 3'b001);

    // R3/R4: real power loss
    main_ok = 0;
    edges_until(0, 40, n);
    chk("R3", "long dip asserts reset", plat_rst_n, 0);
    cur_req = "R4";
    cyc(50);
    chk("R4", "held while main low", plat_rst_n, 0);
    chk("R9", "cause power loss", cause, 3'b001);
    main_ok = 1;
    edges_until(1, 200, n);
    chk("R4", "edges to release after main returns", n, HOLD + 2);

    // R5: write without reset bit
    cur_req = "R5";
    sw_write(8'hFB); cyc(5);
    chk("R5", "write with bit 2 clear ignored", plat_rst_n, 1);
    chk("R5", "cause after ignored write", cause, 3'b001);
    sw_write(8'h04);
    chk("R5", "reset one edge after write", plat_rst_n, 0);
    chk("R9", "cause software replaces", cause, 3'b010);
    edges_until(1, 200, n);
    chk("R5", "edges to release after write", n + 1, HOLD + 1);

    // R8: second write restarts the hold
    cur_req = "R8";
    sw_write(8'h04); cyc(9);
    sw_write(8'h04);
    edges_until(1, 200, n);
    chk("R8", "edges to release after restarting write", n + 1, HOLD + 1);

    // R4/R2: regulator dip in mid-hold
    cur_req = "R2";
    sw_write(8'h04); cyc(5);
    vreg_ok = 0; cyc(30);
    chk("R2", "held while regulator low", plat_rst_n, 0);
    vreg_ok = 1;
    edges_until(1, 200, n);
    chk("R2", "edges to release after regulator returns", n, HOLD + 2);

    // R7: press with SMBus idle
    cur_req = "R7";
    smb = 1; btn_n = 0;
    edges_until(0, 100, n);
    chk("R7", "edges to reset with bus idle", n, DEB + 3);
    chk("R9", "cause button", cause, 3'b100);
    btn_n = 1;
    edges_until(1, 200, n);
    chk("R7", "released after button reset", plat_rst_n, 1);

    // R6: bounce shorter than debounce
    cur_req = "R6";
    cyc(3 * DEB);
    btn_n = 0; cyc(DEB - 2); btn_n = 1;
    cyc(3 * DEB + 10);
    chk("R6", "short press ignored", plat_rst_n, 1);
    chk("R6", "cause after short press", cause, 3'b100);

    // R7: bus never idle, timeout fires
    cur_req = "R7";
    smb = 0; btn_n = 0;
    edges_until(0, 200, n);
    chk("R7", "edges to reset on timeout", n, DEB + TMO + 2);
    btn_n = 1; smb = 1;
    edges_until(1, 200, n);
    cyc(3 * DEB);

    // R8/R9: button during software hold
    cur_req = "R9";
    sw_write(8'h04); cyc(3);
    btn_n = 0; cyc(DEB + 5);
    chk("R9", "causes accumulate", cause, 3'b110);
    btn_n = 1;
    edges_until(1, 200, n);
    chk("R8", "released after combined hold", plat_rst_n, 1);
    cyc(5);
    chk("R9", "cause readable after release", cause, 3'b110);

    finish_run();
  end
endmodule